// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block sends and receives single characters over a half-duplex, open-drain serial line to a smart card. A character is a low start bit, eight data bits sent least significant bit first, and one parity bit, followed by guard time. Every bit lasts one elementary time unit (etu). The etu length is a selectable number of clock cycles. The line idles high. The block never drives it high: it either pulls it low or lets it go.

The transmitter checks for a parity-error signal from the far end and repeats the character when it sees one. The receiver checks parity and, outside block mode, sends that error signal back on the line. A transmit-end flag marks the point where the next character may start. That point depends on the mode: 12.5 etu in normal operation, 11.0 etu in GSM mode or block transfer mode. Software sets a small configuration register and then drives the byte-wide transmit and receive ports.

Top module: `sc_xcvr`

## Requirements
- R1: After reset, all configuration fields read as 0, which means a 32-cycle etu, even parity, normal mode and no block mode. After reset `pullLow`, `txBusy`, `txEnd`, `txErr` and `rxValid` are all 0.
- R2: `cfgWdata[1:0]` sets the etu length. The value 00 gives 32 cycles, 01 gives 64, 10 gives 372 and 11 gives 256.
- R3: A character is accepted on the clock edge where `txStart` is high and the block is idle. Counting from the next cycle as t=0, bit k (k=0 start, 1..8 data LSB first, 9 parity) pulls the line low during [k·S, (k+1)·S) when that bit is 0. From 10·S onward the line is released.
- R4: `cfgWdata[2]` selects the parity type, 0 for even and 1 for odd. The parity bit makes the count of ones in data plus parity even or odd to match. The same rule is used to generate parity and to check it.
- R5: The receiver takes r=0 as the first cycle in which the line is low after being high. It samples bit k at r = k·S + S/2. If the start bit reads high at its sample point, the character is dropped.
- R6: `rxValid` pulses for exactly one cycle at r = 9·S + S/2 + 1. In that same cycle `rxData` holds the data byte and `rxParErr` holds the parity check result.
- R7: Outside block mode, a receive parity error makes the block pull the line low for S cycles, from r = 10·S + S/2 + 1 through r = 11·S + S/2.
- R8: Outside block mode, if the line is low at t = 11·S, `txErr` is set and `txBusy` stays high. The same character is then sent again, and its new t=0 falls at old t = 13·S. `txErr` stays set until the next accepted character.
- R9: In normal mode, when no error is seen, `txEnd` rises and `txBusy` falls at t = 12·S + S/2 + 1.
- R10: In GSM mode (`cfgWdata[4]`=1) without block mode, when no error is seen, `txEnd` rises and `txBusy` falls at t = 11·S + 1.
- R11: In block mode (`cfgWdata[3]`=1), the receiver never drives an error signal and the transmitter ignores the line at 11·S. `txEnd` rises at t = 11·S + 1.
- R12: A `txStart` pulse while busy is ignored. Accepting a new character clears `txEnd` and `txErr`. Reception is not started while transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the etu time base |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 5 | Configuration fields: [4] GSM mode, [3] block mode, [2] odd parity, [1:0] etu select |
| txStart | input | 1 | Request to send `txByte` |
| txByte | input | 8 | Byte to transmit |
| txBusy | output | 1 | A character is being sent or repeated |
| txEnd | output | 1 | Transmit-end flag |
| txErr | output | 1 | An error signal was seen on the current character |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe for a received character |
| rxParErr | output | 1 | Parity result for the last received character |
| lineIn | input | 1 | Sensed level of the open-drain data line |
| pullLow | output | 1 | When high, the line is pulled low |

## Verification
The bench acts as the card. On every clock it compares the pin level against a behavioural frame model. An off-by-one etu counter or a reversed bit order therefore shows up as a pattern mismatch instead of a wrong byte at the end. It places the error pulse so that it covers the 11.0 etu check point. A transmitter that samples at the wrong point would then never retry, or would retry with the wrong 13-etu spacing. It also covers three other cases. In block mode, a design that still reacts to the pulse would raise `txErr`. A short glitch tests start-bit validation: a receiver without that check would deliver a garbage byte. Runs with 372- and 256-cycle etus catch a wrong clock-select decode or a half-etu that is off for the odd-sized setting.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;

  typedef struct packed {
    logic       gsm;
    logic       blk;
    logic       odd;
    logic [1:0] clkSel;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txAccept;
    logic txReload;
    logic txShift;
    logic txDriveEn;
    logic setTxEnd;
    logic setTxErr;
    logic rxShift;
    logic rxFinish;
    logic errDrive;
  } strobe_t;

  localparam int CharBits  = 8;
  localparam int LastBit   = 9;   // parity bit index within the frame
  localparam int ChkEtu    = 11;  // error-signal check point (etu)
  localparam int RetryEtu  = 12;  // last etu before a repeat starts

endpackage

// File: rtl/sc_xcvr_ctrl.sv
module sc_xcvr_ctrl
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_SEL0 = 32,
  parameter int ETU_SEL1 = 64,
  parameter int ETU_SEL2 = 372,
  parameter int ETU_SEL3 = 256
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    txStart,
  input  logic    lineIn,
  input  logic    rxParErr,
  output strobe_t stb,
  output logic    txBusy,
  output logic    rxBusy
);

  localparam int Max01  = (ETU_SEL0 > ETU_SEL1) ? ETU_SEL0 : ETU_SEL1;
  localparam int Max23  = (ETU_SEL2 > ETU_SEL3) ? ETU_SEL2 : ETU_SEL3;
  localparam int MaxEtu = (Max01 > Max23) ? Max01 : Max23;
  localparam int CW     = $clog2(MaxEtu);
  localparam int EW     = 4;

  logic [CW-1:0] etuLen, halfLen, lastCyc;

  always_comb begin
    case (cfg.clkSel)
      2'b00:   etuLen = CW'(ETU_SEL0);
      2'b01:   etuLen = CW'(ETU_SEL1);
      2'b10:   etuLen = CW'(ETU_SEL2);
      default: etuLen = CW'(ETU_SEL3);
    endcase
  end
  assign halfLen = etuLen >> 1;
  assign lastCyc = etuLen - CW'(1);

  // transmit timing
  logic          txActive, retry;
  logic [EW-1:0] tEtu;
  logic [CW-1:0] tCyc;
  // receive timing
  logic          rxActive, errOn, prevLine;
  logic [EW-1:0] rEtu;
  logic [CW-1:0] rCyc;

  logic accept, tEnd, chk11, rEnd, rMid, rxStart;

  assign accept  = txStart && !txActive && !rxActive;
  assign tEnd    = (tCyc == lastCyc);
  assign chk11   = txActive && (tEtu == EW'(ChkEtu)) && (tCyc == '0);
  assign rEnd    = (rCyc == lastCyc);
  assign rMid    = (rCyc == halfLen);
  assign rxStart = !txActive && !rxActive && !accept && prevLine && !lineIn;

  always_comb begin
    stb           = '0;
    stb.txAccept  = accept;
    stb.txShift   = txActive && tEnd;
    stb.txReload  = txActive && tEnd && retry && (tEtu == EW'(RetryEtu));
    stb.txDriveEn = txActive && (tEtu <= EW'(LastBit));
    stb.setTxErr  = chk11 && !cfg.blk && !lineIn;
    stb.setTxEnd  = (chk11 && (cfg.blk || (cfg.gsm && lineIn))) ||
                    (txActive && !retry && (tEtu == EW'(RetryEtu)) && (tCyc == halfLen));
    stb.rxShift   = rxActive && rMid && (rEtu >= EW'(1)) && (rEtu <= EW'(CharBits));
    stb.rxFinish  = rxActive && rMid && (rEtu == EW'(LastBit));
    stb.errDrive  = errOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      retry    <= 1'b0;
      tEtu     <= '0;
      tCyc     <= '0;
    end else if (accept) begin
      txActive <= 1'b1;
      retry    <= 1'b0;
      tEtu     <= '0;
      tCyc     <= '0;
    end else if (txActive) begin
      if (tEnd) begin
        tCyc <= '0;
        if (stb.txReload) begin
          tEtu  <= '0;
          retry <= 1'b0;
        end else begin
          tEtu <= tEtu + EW'(1);
        end
      end else begin
        tCyc <= tCyc + CW'(1);
      end
      if (stb.setTxErr) retry    <= 1'b1;
      if (stb.setTxEnd) txActive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      errOn    <= 1'b0;
      prevLine <= 1'b1;
      rEtu     <= '0;
      rCyc     <= '0;
    end else begin
      prevLine <= lineIn;
      if (rxStart) begin
        rxActive <= 1'b1;
        rEtu     <= '0;
        rCyc     <= CW'(1);
      end else if (rxActive) begin
        if (rEnd) begin
          rCyc <= '0;
          rEtu <= rEtu + EW'(1);
        end else begin
          rCyc <= rCyc + CW'(1);
        end
        if (rMid && (rEtu == '0) && lineIn) rxActive <= 1'b0;
        if (rMid && (rEtu == EW'(LastBit + 1))) begin
          if (!cfg.blk && rxParErr) errOn    <= 1'b1;
          else                      rxActive <= 1'b0;
        end
        if (rMid && (rEtu == EW'(ChkEtu))) begin
          errOn    <= 1'b0;
          rxActive <= 1'b0;
        end
      end
    end
  end

  assign txBusy = txActive;
  assign rxBusy = rxActive;

endmodule

// File: rtl/sc_xcvr_dp.sv
module sc_xcvr_dp
  import sc_xcvr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [4:0]    cfgWdata,
  input  strobe_t       stb,
  input  logic [CharBits-1:0] txByte,
  input  logic          lineIn,
  output cfg_t          cfg,
  output logic          pullLow,
  output logic          txEnd,
  output logic          txErr,
  output logic [CharBits-1:0] rxData,
  output logic          rxValid,
  output logic          rxParErr
);

  localparam int FrameW = CharBits + 2;

  function automatic logic parBit(input logic [CharBits-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  logic [CharBits-1:0] txHold, rxSh;
  logic [FrameW-1:0]   txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (cfgWe) cfg <= cfg_t'(cfgWdata);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txSh   <= '1;
      txEnd  <= 1'b0;
      txErr  <= 1'b0;
    end else begin
      if (stb.txAccept) begin
        txHold <= txByte;
        txSh   <= {parBit(txByte, cfg.odd), txByte, 1'b0};
        txEnd  <= 1'b0;
        txErr  <= 1'b0;
      end else if (stb.txReload) begin
        txSh <= {parBit(txHold, cfg.odd), txHold, 1'b0};
      end else if (stb.txShift) begin
        txSh <= {1'b1, txSh[FrameW-1:1]};
      end
      if (stb.setTxEnd) txEnd <= 1'b1;
      if (stb.setTxErr) txErr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      rxParErr <= 1'b0;
    end else begin
      rxValid <= stb.rxFinish;
      if (stb.rxShift) rxSh <= {lineIn, rxSh[CharBits-1:1]};
      if (stb.rxFinish) begin
        rxData   <= rxSh;
        rxParErr <= ((^rxSh) ^ lineIn) != cfg.odd;
      end
    end
  end

  assign pullLow = (stb.txDriveEn && !txSh[0]) || stb.errDrive;

endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_SEL0 = 32,
  parameter int ETU_SEL1 = 64,
  parameter int ETU_SEL2 = 372,
  parameter int ETU_SEL3 = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [4:0] cfgWdata,
  input  logic       txStart,
  input  logic [7:0] txByte,
  output logic       txBusy,
  output logic       txEnd,
  output logic       txErr,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxParErr,
  input  logic       lineIn,
  output logic       pullLow
);

  cfg_t    cfg;
  strobe_t stb;
  logic    rxBusy;
  logic    cfgBlk;

  assign cfgBlk = cfg.blk;

  sc_xcvr_ctrl #(
    .ETU_SEL0(ETU_SEL0), .ETU_SEL1(ETU_SEL1),
    .ETU_SEL2(ETU_SEL2), .ETU_SEL3(ETU_SEL3)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .txStart(txStart), .lineIn(lineIn),
    .rxParErr(rxParErr), .stb(stb), .txBusy(txBusy), .rxBusy(rxBusy)
  );

  sc_xcvr_dp dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .stb(stb),
    .txByte(txByte), .lineIn(lineIn), .cfg(cfg), .pullLow(pullLow),
    .txEnd(txEnd), .txErr(txErr), .rxData(rxData), .rxValid(rxValid),
    .rxParErr(rxParErr)
  );

endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
  input logic clk,
  input logic rstN,
  input logic txStart,
  input logic txBusy,
  input logic txEnd,
  input logic txErr,
  input logic rxValid,
  input logic pullLow,
  input logic rxBusy,
  input logic cfgBlk
);

  AST_RXVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R6

  AST_TXEND_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txEnd |-> !txBusy); // R9

  AST_BLK_NO_ERRSIG: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBlk && !txBusy) |-> !pullLow); // R11

  AST_TXERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !(txStart && !txBusy)) |=> txErr); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && !txBusy && !rxBusy) |=> txBusy); // R12

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !rxBusy); // R12

endmodule

bind sc_xcvr sc_xcvr_chk chk_i (
  .clk(clk), .rstN(rstN), .txStart(txStart), .txBusy(txBusy), .txEnd(txEnd),
  .txErr(txErr), .rxValid(rxValid), .pullLow(pullLow), .rxBusy(rxBusy),
  .cfgBlk(cfgBlk)
);

// File: tb/sc_xcvr_tb.sv
module sc_xcvr_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgWdata = '0;
  logic       txStart = 1'b0;
  logic [7:0] txByte = '0;
  logic       txBusy, txEnd, txErr, rxValid, rxParErr, pullLow;
  logic [7:0] rxData;
  logic       cardLow = 1'b0;
  logic       lineIn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign lineIn = !(pullLow || cardLow);

  sc_xcvr dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .txStart(txStart), .txByte(txByte), .txBusy(txBusy), .txEnd(txEnd),
    .txErr(txErr), .rxData(rxData), .rxValid(rxValid), .rxParErr(rxParErr),
    .lineIn(lineIn), .pullLow(pullLow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int etuOf(input int sel);
    case (sel)
      0: return 32;
      1: return 64;
      2: return 372;
      default: return 256;
    endcase
  endfunction

  function automatic bit parOf(input logic [7:0] b, input bit odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return bit'(ones % 2) ^ odd;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input bit gsm, input bit blk, input bit odd, input int sel);
    cfgWe = 1'b1;
    cfgWdata = {gsm, blk, odd, 2'(sel)};
    @(negedge clk);
    cfgWe = 1'b0;
    @(negedge clk);
  endtask

  // transmit one character while acting as the card
  task automatic runTx(input logic [7:0] b, input int sel, input bit odd,
                       input bit gsm, input bit blk, input int errCount,
                       input bit poke, input string req);
    int S = etuOf(sel);
    bit fr[10];
    int mism = 0;
    int attempt = 0;
    bit finished = 0;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++) fr[i+1] = b[i];
    fr[9] = parOf(b, odd);
    txStart = 1'b1;
    txByte  = b;
    @(negedge clk);
    txStart = 1'b0;
    while (!finished) begin
      bit cardErr = (attempt < errCount);
      bit seenErr = cardErr && !blk;
      int endT = (blk || gsm) ? 11*S + 1 : 12*S + S/2 + 1;
      for (int t = 0; ; t++) begin
        bit expPull;
        cardLow = cardErr && (t >= 10*S + S/2) && (t < 11*S + S/2);
        expPull = (t < 10*S) && (fr[t/S] == 1'b0);
        if (pullLow != expPull) mism++;
        if (poke && attempt == 0 && t == 3*S) begin txStart = 1'b1; txByte = ~b; end
        if (poke && attempt == 0 && t == 3*S + 1) txStart = 1'b0;
        if (t == 11*S + 1)
          check(txErr == (!blk && errCount > 0 && (attempt > 0 || seenErr)),
                req, "txErr after 11 etu check", txErr, int'(!blk && errCount > 0));
        if (seenErr) begin
          if (t == 12*S + S/2 + 1)
            check(txBusy && !txEnd, "R8", "busy held for repeat", txBusy, 1);
          if (t == 13*S - 1) begin
            @(negedge clk);
            break;
          end
        end else begin
          if (t == endT - 1)
            check(txBusy && !txEnd, req, "txEnd before end point", txEnd, 0);
          if (t == endT)
            check(!txBusy && txEnd, req, "txEnd at end point", txEnd, 1);
          if (t == endT + S) begin
            finished = 1;
            break;
          end
        end
        @(negedge clk);
      end
      attempt++;
    end
    cardLow = 1'b0;
    check(mism == 0, req, "line pattern mismatch cycles", mism, 0);
  endtask

  // receive one character driven by the card
  task automatic runRx(input logic [7:0] b, input int sel, input bit odd,
                       input bit badPar, input bit blk, input string req);
    int S = etuOf(sel);
    bit fr[10];
    int mism = 0;
    int vmis = 0;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++) fr[i+1] = b[i];
    fr[9] = parOf(b, odd) ^ badPar;
    for (int r = 0; r < 13*S; r++) begin
      bit expPull;
      cardLow = (r < 10*S) && (fr[r/S] == 1'b0);
      expPull = badPar && !blk && (r >= 10*S + S/2 + 1) && (r <= 11*S + S/2);
      if (pullLow != expPull) mism++;
      if (rxValid != (r == 9*S + S/2 + 1)) vmis++;
      if (r == 9*S + S/2 + 1) begin
        check(rxData == b, req, "rxData", rxData, b);
        check(rxParErr == badPar, req, "rxParErr", rxParErr, badPar);
      end
      @(negedge clk);
    end
    cardLow = 1'b0;
    check(mism == 0, req, "error signal cycles mismatch", mism, 0);
    check(vmis == 0, "R6", "rxValid strobe cycles mismatch", vmis, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    check(!pullLow && !txBusy && !txEnd && !txErr && !rxValid, "R1",
          "idle outputs after reset", int'({pullLow, txBusy, txEnd, txErr, rxValid}), 0);
    idle(5);
    // defaults: 32-cycle etu, even parity, normal mode
    runTx(8'hA5, 0, 0, 0, 0, 0, 0, "R1,R3,R9");
    setCfg(0, 0, 1, 1);
    runTx(8'h3C, 1, 1, 0, 0, 0, 1, "R2,R4,R12");
    setCfg(1, 0, 0, 0);
    runTx(8'h81, 0, 0, 1, 0, 0, 0, "R10");
    setCfg(0, 0, 0, 0);
    runTx(8'h5A, 0, 0, 0, 0, 1, 0, "R8");
    runTx(8'h0F, 0, 0, 0, 0, 0, 0, "R12");
    setCfg(0, 1, 0, 0);
    runTx(8'hC3, 0, 0, 0, 1, 1, 0, "R11");
    setCfg(0, 0, 0, 2);
    runTx(8'hF0, 2, 0, 0, 0, 0, 0, "R2");
    setCfg(0, 0, 0, 0);
    idle(8);
    runRx(8'h6B, 0, 0, 0, 0, "R5,R6");
    idle(40);
    runRx(8'h92, 0, 0, 1, 0, "R7");
    idle(40);
    setCfg(0, 1, 0, 0);
    runRx(8'h17, 0, 0, 1, 1, "R11");
    setCfg(0, 0, 0, 0);
    idle(40);
    // false start: short glitch below half an etu
    begin
      int badV = 0;
      int badP = 0;
      cardLow = 1'b1;
      idle(5);
      cardLow = 1'b0;
      for (int i = 0; i < 3*32; i++) begin
        if (rxValid) badV++;
        if (pullLow) badP++;
        @(negedge clk);
      end
      check(badV == 0 && badP == 0, "R5", "glitch produced activity", badV + badP, 0);
    end
    runRx(8'h44, 0, 0, 0, 0, "R5");
    idle(40);
    setCfg(0, 0, 1, 3);
    runRx(8'hD6, 3, 1, 0, 0, "R2,R4");
    idle(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule